// File: doc/BRIEF.md
# Multi-Source Event Fragment Builder

This block gathers the readout of up to twelve front-end sources into a single output event fragment for each trigger accept. Each source offers two first-word-fall-through queues. A management queue holds one record per event: event number, bunch number and payload length. A data queue holds the 32-bit payload words. A separate queue holds timing records, each carrying the event and bunch number of one accept. Software provides a mask of the sources that are present. Each source also has a link-up flag.

Once a timing record is waiting and the output memory reports room for a fragment, a wait timer runs. Building starts early if every enabled source is ready, meaning its link is down or its management record has arrived. Otherwise it starts when the timer reaches its configured limit. The fragment is then written one 32-bit word per cycle through `out_we`/`out_word`.

The fragment is laid out as follows:
- an outer transport header;
- a two-word standard header;
- the qualifying sources in ascending index order;
- two status words;
- a word count;
- an outer trailer.

The status words record, per source, which sources had their link down, which timed out and which disagreed with the header event or bunch number.

Top module: `frag_assembler`

## Requirements
- R1: While reset is held, and in the first cycle after it, `out_we`, `trig_pop`, every `mgmt_pop` bit and every `dat_pop` bit are low.
- R2: No fragment word is written unless a timing record is waiting and `out_space` is high. With `out_space` low, `out_we` stays low however long a record waits.
- R3: When a record is waiting, `out_space` is high and every enabled source has either its link down or a management record waiting, the first fragment word is written in the cycle after the first clock edge that sees this condition.
- R4: Otherwise the timer counts clock edges from the first edge at which a record is waiting with `out_space` high. The first fragment word is written `cfg_timeout`+1 cycles after that point.
- R5: The word order is fixed:
  - `cfg_xport_hdr`;
  - `cfg_frag_id`;
  - the header word {event[19:0], bunch[11:0]} taken from the timing record (event in bits 31:12);
  - the source sections for indices 0 to 11 in ascending order;
  - status word A = {timeout bits in 31:16, link-down bits in 15:0}, with bit i standing for source i;
  - status word B = {16'b0, mismatch bits in 15:0};
  - the word count;
  - `cfg_xport_trl`.
- R6: A source whose `src_en` bit is clear contributes no words and no status bits, and its queues are never popped.
- R7: An enabled source whose link is down when building starts sets its link-down bit and contributes no words.
- R8: An enabled source with its link up but no management record when building starts sets its timeout bit and contributes no words.
- R9: A source whose management event or bunch number differs from the header sets its mismatch bit. Its own {event, bunch} word is written immediately before its payload.
- R10: A contributing source's payload is exactly the management length in words. It is copied in queue order, with one `dat_pop` per word written. The management record is popped once when the source is finished, and a length of zero copies nothing.
- R11: The word count equals the number of words from `cfg_frag_id` through the count word itself, inclusive.
- R12: The timing record is popped exactly once per fragment, in the cycle that writes the header event/bunch word.
- R13: While the selected source's data queue is empty during its payload, `out_we` is low and nothing is popped. Copying resumes when data arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_timeout | input | 16 | Wait timer limit in cycles |
| cfg_xport_hdr | input | 32 | Outer transport header word |
| cfg_xport_trl | input | 32 | Outer transport trailer word |
| cfg_frag_id | input | 32 | First standard header word |
| src_en | input | 12 | Source presence mask |
| link_up | input | 12 | Per-source link-up flags |
| out_space | input | 1 | Output memory can take a fragment |
| trig_valid | input | 1 | Timing record queue not empty |
| trig_evt | input | 20 | Event number of head timing record |
| trig_bc | input | 12 | Bunch number of head timing record |
| trig_pop | output | 1 | Pop the timing record queue |
| mgmt_valid | input | 12 | Per-source management queue not empty |
| mgmt_evt | input | 240 | Per-source event numbers, source i in bits [20i+19:20i] |
| mgmt_bc | input | 144 | Per-source bunch numbers, source i in bits [12i+11:12i] |
| mgmt_len | input | 96 | Per-source payload lengths, source i in bits [8i+7:8i] |
| mgmt_pop | output | 12 | Per-source management queue pop |
| dat_valid | input | 12 | Per-source data queue not empty |
| dat_word | input | 384 | Per-source head data words, source i in bits [32i+31:32i] |
| dat_pop | output | 12 | Per-source data queue pop |
| out_we | output | 1 | Output word write strobe |
| out_word | output | 32 | Output word |

## Verification
The first word of a fragment is due one cycle after the edge on which the start condition is seen when all sources are ready. When sources are not all ready, it is due `cfg_timeout`+1 cycles after arming. The bench counts falling edges from the moment it presents the timing record and compares that count with the value derived from R3/R4.

After the first word, one word follows per cycle, except while a selected data queue is empty. Because of this, the fragment content is checked as an ordered scoreboard that is sampled only on cycles where `out_we` is high, so stalls do not shift the comparison.

Queue pops are observed on the falling edge and applied just after the next rising edge. The source queue contents the bench holds therefore show exactly which entries the block consumed.

// File: rtl/frag_pkg.sv
// Shared definitions for the event fragment builder.
// Assumes a 32-bit output word that holds event and bunch number side by side.
package frag_pkg;

    localparam int FRAG_W = 32;

    typedef enum logic [3:0] {
        S_IDLE,
        S_XHDR,
        S_SHDR0,
        S_SHDR1,
        S_SCAN,
        S_MISM,
        S_PAY,
        S_ST0,
        S_ST1,
        S_CNT,
        S_XTRL
    } frag_state_e;

endpackage

// File: rtl/frag_wait_timer.sv
// Wait timer: counts cycles while armed and flags expiry at the configured limit.
// Assumes arm drops once a build starts, which clears the count.
module frag_wait_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [TMR_W-1:0] limit,
    output logic             expired
);

    logic [TMR_W-1:0] cnt;

    assign expired = arm && (cnt == limit);

    // Count up while armed, hold at the limit, clear when disarmed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!arm) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/frag_src_view.sv
// Per-source view: slices the flat source buses, derives readiness and
// start-time status, and selects the fields of the source at idx.
// Assumes EVT_W + BC_W equals the output word width.
module frag_src_view
    import frag_pkg::*;
#(
    parameter int N_SRC = 12,
    parameter int EVT_W = 20,
    parameter int BC_W  = 12,
    parameter int LEN_W = 8,
    parameter int IDX_W = 4
) (
    input  logic [N_SRC-1:0]        src_en,
    input  logic [N_SRC-1:0]        link_up,
    input  logic [N_SRC-1:0]        mgmt_valid,
    input  logic [N_SRC*EVT_W-1:0]  mgmt_evt,
    input  logic [N_SRC*BC_W-1:0]   mgmt_bc,
    input  logic [N_SRC*LEN_W-1:0]  mgmt_len,
    input  logic [N_SRC-1:0]        dat_valid,
    input  logic [N_SRC*FRAG_W-1:0] dat_word,
    input  logic [IDX_W-1:0]        idx,
    input  logic [N_SRC-1:0]        ld_snap,
    input  logic [N_SRC-1:0]        to_snap,
    input  logic [EVT_W-1:0]        hdr_evt,
    input  logic [BC_W-1:0]         hdr_bc,
    output logic                    all_ready,
    output logic [N_SRC-1:0]        ld_now,
    output logic [N_SRC-1:0]        to_now,
    output logic                    sel_take,
    output logic                    sel_mism,
    output logic [LEN_W-1:0]        sel_len,
    output logic [FRAG_W-1:0]       sel_id,
    output logic                    sel_dvalid,
    output logic [FRAG_W-1:0]       sel_dword
);

    logic [EVT_W-1:0]  evt_a [N_SRC];
    logic [BC_W-1:0]   bc_a  [N_SRC];
    logic [LEN_W-1:0]  len_a [N_SRC];
    logic [FRAG_W-1:0] dat_a [N_SRC];
    logic [N_SRC-1:0]  ready_v;
    logic [IDX_W-1:0]  sidx;
    logic              in_range;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign evt_a[g]   = mgmt_evt[g*EVT_W +: EVT_W];
        assign bc_a[g]    = mgmt_bc[g*BC_W +: BC_W];
        assign len_a[g]   = mgmt_len[g*LEN_W +: LEN_W];
        assign dat_a[g]   = dat_word[g*FRAG_W +: FRAG_W];
        assign ready_v[g] = !src_en[g] || !link_up[g] || mgmt_valid[g];
        assign ld_now[g]  = src_en[g] && !link_up[g];
        assign to_now[g]  = src_en[g] && link_up[g] && !mgmt_valid[g];
    end

    assign all_ready  = &ready_v;
    assign in_range   = (idx < IDX_W'(N_SRC));
    assign sidx       = in_range ? idx : '0;
    assign sel_take   = in_range && src_en[sidx] && !ld_snap[sidx] && !to_snap[sidx];
    assign sel_mism   = (evt_a[sidx] != hdr_evt) || (bc_a[sidx] != hdr_bc);
    assign sel_len    = len_a[sidx];
    assign sel_id     = FRAG_W'({evt_a[sidx], bc_a[sidx]});
    assign sel_dvalid = in_range && dat_valid[sidx];
    assign sel_dword  = dat_a[sidx];

endmodule

// File: rtl/frag_assembler.sv
// Event fragment builder top: waits for a timing record and ready sources (or
// a timeout), then writes transport header, standard header, per-source
// sections in ascending order, status, word count and transport trailer.
// Assumes out_space stays high for the duration of one fragment and that a
// source's data queue eventually holds its full payload.
module frag_assembler
    import frag_pkg::*;
#(
    parameter int N_SRC = 12,
    parameter int EVT_W = 20,
    parameter int BC_W  = 12,
    parameter int LEN_W = 8,
    parameter int TMR_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [TMR_W-1:0]        cfg_timeout,
    input  logic [FRAG_W-1:0]       cfg_xport_hdr,
    input  logic [FRAG_W-1:0]       cfg_xport_trl,
    input  logic [FRAG_W-1:0]       cfg_frag_id,
    input  logic [N_SRC-1:0]        src_en,
    input  logic [N_SRC-1:0]        link_up,
    input  logic                    out_space,
    input  logic                    trig_valid,
    input  logic [EVT_W-1:0]        trig_evt,
    input  logic [BC_W-1:0]         trig_bc,
    output logic                    trig_pop,
    input  logic [N_SRC-1:0]        mgmt_valid,
    input  logic [N_SRC*EVT_W-1:0]  mgmt_evt,
    input  logic [N_SRC*BC_W-1:0]   mgmt_bc,
    input  logic [N_SRC*LEN_W-1:0]  mgmt_len,
    output logic [N_SRC-1:0]        mgmt_pop,
    input  logic [N_SRC-1:0]        dat_valid,
    input  logic [N_SRC*FRAG_W-1:0] dat_word,
    output logic [N_SRC-1:0]        dat_pop,
    output logic                    out_we,
    output logic [FRAG_W-1:0]       out_word
);

    localparam int IDX_W  = $clog2(N_SRC + 1);
    localparam int CNT_W  = 16;
    localparam int HALF_W = FRAG_W / 2;

    frag_state_e      st;
    logic [IDX_W-1:0] idx;
    logic [LEN_W-1:0] rem;
    logic [N_SRC-1:0] ld_s, to_s, mm_s;
    logic [CNT_W-1:0] wcnt;
    logic [EVT_W-1:0] hdr_evt;
    logic [BC_W-1:0]  hdr_bc;

    logic             arm, expired, all_ready, go;
    logic [N_SRC-1:0] ld_now, to_now;
    logic             sel_take, sel_mism, sel_dvalid;
    logic [LEN_W-1:0] sel_len;
    logic [FRAG_W-1:0] sel_id, sel_dword;
    logic             pop_m, pop_d;

    assign arm = (st == S_IDLE) && trig_valid && out_space;
    assign go  = arm && (all_ready || expired);

    frag_wait_timer #(.TMR_W(TMR_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .limit   (cfg_timeout),
        .expired (expired)
    );

    frag_src_view #(
        .N_SRC(N_SRC), .EVT_W(EVT_W), .BC_W(BC_W), .LEN_W(LEN_W), .IDX_W(IDX_W)
    ) u_view (
        .src_en     (src_en),
        .link_up    (link_up),
        .mgmt_valid (mgmt_valid),
        .mgmt_evt   (mgmt_evt),
        .mgmt_bc    (mgmt_bc),
        .mgmt_len   (mgmt_len),
        .dat_valid  (dat_valid),
        .dat_word   (dat_word),
        .idx        (idx),
        .ld_snap    (ld_s),
        .to_snap    (to_s),
        .hdr_evt    (hdr_evt),
        .hdr_bc     (hdr_bc),
        .all_ready  (all_ready),
        .ld_now     (ld_now),
        .to_now     (to_now),
        .sel_take   (sel_take),
        .sel_mism   (sel_mism),
        .sel_len    (sel_len),
        .sel_id     (sel_id),
        .sel_dvalid (sel_dvalid),
        .sel_dword  (sel_dword)
    );

    // Management pop: zero-length finish in scan or mismatch, or last payload word.
    always_comb begin
        pop_m = 1'b0;
        if (st == S_SCAN && sel_take && !sel_mism && sel_len == '0) pop_m = 1'b1;
        if (st == S_MISM && sel_len == '0) pop_m = 1'b1;
        if (st == S_PAY && sel_dvalid && rem == LEN_W'(1)) pop_m = 1'b1;
    end

    assign pop_d    = (st == S_PAY) && sel_dvalid;
    assign trig_pop = (st == S_SHDR1);

    for (genvar g = 0; g < N_SRC; g++) begin : g_pop
        assign mgmt_pop[g] = pop_m && (idx == IDX_W'(g));
        assign dat_pop[g]  = pop_d && (idx == IDX_W'(g));
    end

    // Output word selection by state.
    always_comb begin
        out_we   = 1'b1;
        out_word = '0;
        unique case (st)
            S_XHDR:  out_word = cfg_xport_hdr;
            S_SHDR0: out_word = cfg_frag_id;
            S_SHDR1: out_word = FRAG_W'({hdr_evt, hdr_bc});
            S_MISM:  out_word = sel_id;
            S_PAY: begin
                out_we   = sel_dvalid;
                out_word = sel_dword;
            end
            S_ST0:   out_word = {HALF_W'(to_s), HALF_W'(ld_s)};
            S_ST1:   out_word = {{HALF_W{1'b0}}, HALF_W'(mm_s)};
            S_CNT:   out_word = FRAG_W'(wcnt) + 1'b1;
            S_XTRL:  out_word = cfg_xport_trl;
            default: out_we   = 1'b0;
        endcase
    end

    // Fragment sequencer: start, header, source scan, payload copy, trailer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            idx     <= '0;
            rem     <= '0;
            ld_s    <= '0;
            to_s    <= '0;
            mm_s    <= '0;
            wcnt    <= '0;
            hdr_evt <= '0;
            hdr_bc  <= '0;
        end else begin
            unique case (st)
                S_IDLE: if (go) begin
                    st      <= S_XHDR;
                    ld_s    <= ld_now;
                    to_s    <= to_now;
                    mm_s    <= '0;
                    idx     <= '0;
                    wcnt    <= '0;
                    hdr_evt <= trig_evt;
                    hdr_bc  <= trig_bc;
                end
                S_XHDR:  st <= S_SHDR0;
                S_SHDR0: begin
                    st   <= S_SHDR1;
                    wcnt <= wcnt + 1'b1;
                end
                S_SHDR1: begin
                    st   <= S_SCAN;
                    wcnt <= wcnt + 1'b1;
                end
                S_SCAN: begin
                    if (idx == IDX_W'(N_SRC)) begin
                        st <= S_ST0;
                    end else if (sel_take && sel_mism) begin
                        mm_s[idx] <= 1'b1;
                        st        <= S_MISM;
                    end else if (sel_take && sel_len != '0) begin
                        rem <= sel_len;
                        st  <= S_PAY;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                S_MISM: begin
                    wcnt <= wcnt + 1'b1;
                    if (sel_len == '0) begin
                        idx <= idx + 1'b1;
                        st  <= S_SCAN;
                    end else begin
                        rem <= sel_len;
                        st  <= S_PAY;
                    end
                end
                S_PAY: if (sel_dvalid) begin
                    wcnt <= wcnt + 1'b1;
                    rem  <= rem - 1'b1;
                    if (rem == LEN_W'(1)) begin
                        idx <= idx + 1'b1;
                        st  <= S_SCAN;
                    end
                end
                S_ST0: begin
                    st   <= S_ST1;
                    wcnt <= wcnt + 1'b1;
                end
                S_ST1: begin
                    st   <= S_CNT;
                    wcnt <= wcnt + 1'b1;
                end
                S_CNT:   st <= S_XTRL;
                S_XTRL:  st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/frag_assembler_chk.sv
// Protocol checker for the fragment builder, attached by bind.
// Assumes st is the sequencer state of the bound instance.
module frag_assembler_chk
    import frag_pkg::*;
#(
    parameter int N_SRC = 12
) (
    input logic             clk,
    input logic             rst_n,
    input frag_state_e      st,
    input logic             trig_valid,
    input logic             trig_pop,
    input logic             out_space,
    input logic             out_we,
    input logic [N_SRC-1:0] mgmt_pop,
    input logic [N_SRC-1:0] dat_pop,
    input logic [N_SRC-1:0] dat_valid
);

    // R12
    trig_pop_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pop |-> trig_valid);

    // R2
    start_needs_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_XHDR) |-> $past(trig_valid && out_space));

    // R10
    mgmt_pop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mgmt_pop));

    // R10
    dat_pop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dat_pop));

    // R10
    dat_pop_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|dat_pop) |-> out_we);

    // R13
    dat_pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|dat_pop) |-> ((dat_pop & ~dat_valid) == '0));

endmodule

bind frag_assembler frag_assembler_chk #(.N_SRC(N_SRC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st         (st),
    .trig_valid (trig_valid),
    .trig_pop   (trig_pop),
    .out_space  (out_space),
    .out_we     (out_we),
    .mgmt_pop   (mgmt_pop),
    .dat_pop    (dat_pop),
    .dat_valid  (dat_valid)
);

// File: tb/sim_frag_assembler.sv
// Scoreboard bench: each event task pushes the expected fragment words,
// a monitor pops and compares them whenever out_we is sampled high.
module sim_frag_assembler;

    localparam int N  = 12;
    localparam int EW = 20;
    localparam int BW = 12;
    localparam int LW = 8;

    localparam logic [31:0] XH  = 32'h5A5A_0001;
    localparam logic [31:0] XT  = 32'h5A5A_00FE;
    localparam logic [31:0] FID = 32'h0012_3400;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   cfg_timeout = 16'd10;
    logic [N-1:0]  src_en = '0, link_up = '0;
    logic          out_space = 1'b1;
    logic          trig_valid = 1'b0;
    logic [EW-1:0] trig_evt = '0;
    logic [BW-1:0] trig_bc = '0;
    logic          trig_pop;
    logic [N-1:0]  mgmt_valid = '0;
    logic [N*EW-1:0] mgmt_evt = '0;
    logic [N*BW-1:0] mgmt_bc = '0;
    logic [N*LW-1:0] mgmt_len = '0;
    logic [N-1:0]  mgmt_pop;
    logic [N-1:0]  dat_valid = '0;
    logic [N*32-1:0] dat_word = '0;
    logic [N-1:0]  dat_pop;
    logic          out_we;
    logic [31:0]   out_word;

    always #5 clk = ~clk;

    frag_assembler u0 (
        .clk(clk), .rst_n(rst_n), .cfg_timeout(cfg_timeout),
        .cfg_xport_hdr(XH), .cfg_xport_trl(XT), .cfg_frag_id(FID),
        .src_en(src_en), .link_up(link_up), .out_space(out_space),
        .trig_valid(trig_valid), .trig_evt(trig_evt), .trig_bc(trig_bc),
        .trig_pop(trig_pop), .mgmt_valid(mgmt_valid), .mgmt_evt(mgmt_evt),
        .mgmt_bc(mgmt_bc), .mgmt_len(mgmt_len), .mgmt_pop(mgmt_pop),
        .dat_valid(dat_valid), .dat_word(dat_word), .dat_pop(dat_pop),
        .out_we(out_we), .out_word(out_word)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Source queue model: one management entry per source, up to 8 data words.
    bit          m_has [N];
    logic [EW-1:0] m_evt [N];
    logic [BW-1:0] m_bc  [N];
    int          m_len [N];
    logic [31:0] d_mem [N][8];
    int          d_cnt [N];
    int          d_rd  [N];
    bit          t_has = 0;
    int          stall = 0;

    logic [31:0] exp_q [$];
    string       exp_r [$];

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive();
        for (int i = 0; i < N; i++) begin
            mgmt_valid[i]        = m_has[i];
            mgmt_evt[i*EW +: EW] = m_evt[i];
            mgmt_bc[i*BW +: BW]  = m_bc[i];
            mgmt_len[i*LW +: LW] = LW'(m_len[i]);
            dat_valid[i]         = (d_rd[i] < d_cnt[i]) && (stall == 0);
            dat_word[i*32 +: 32] = (d_rd[i] < 8) ? d_mem[i][d_rd[i]] : 32'h0;
        end
        trig_valid = t_has;
    endtask

    // Queue model: sample pops mid-cycle, apply them just after the edge.
    always begin
        logic [N-1:0] pm, pd;
        logic         pt;
        @(negedge clk);
        pm = mgmt_pop; pd = dat_pop; pt = trig_pop;
        @(posedge clk);
        #1;
        for (int i = 0; i < N; i++) begin
            if (pm[i]) m_has[i] = 0;
            if (pd[i]) d_rd[i]++;
        end
        if (pt) t_has = 0;
        if (stall > 0) stall--;
        drive();
    end

    // Monitor: compare every written word against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && out_we) begin
            if (exp_q.size() == 0) begin
                check(0, "R5 unexpected word", out_word, 32'h0);
            end else begin
                logic [31:0] e;
                string r;
                e = exp_q.pop_front();
                r = exp_r.pop_front();
                check(out_word === e, r, out_word, e);
            end
        end
    end

    task automatic push(input logic [31:0] w, input string r);
        exp_q.push_back(w);
        exp_r.push_back(r);
    endtask

    logic [EW-1:0] evt_n = 20'h00100;

    // One fragment: en/lu/have masks, event and bunch mismatch masks,
    // timeout, data stall cycles, cycles with out_space held low first.
    task automatic run_event(input logic [N-1:0] en, input logic [N-1:0] lu,
                             input logic [N-1:0] have, input logic [N-1:0] me,
                             input logic [N-1:0] mb, input int tmo,
                             input int stl, input int nospace, input string tag);
        logic [BW-1:0] bc;
        logic [15:0] ldb, tob, mmb;
        int          nstd, lat, expl, guard, seen;
        bit          rdy;
        @(negedge clk);
        evt_n = evt_n + 20'd3;
        bc    = BW'(evt_n[7:0]) + 12'd40;
        cfg_timeout = 16'(tmo);
        src_en  = en;
        link_up = lu;
        ldb = '0; tob = '0; mmb = '0;
        rdy = 1;
        push(XH, "R5 xport header");
        push(FID, "R5 frag id");
        push({evt_n, bc}, "R5 header evt/bc");
        nstd = 2;
        for (int i = 0; i < N; i++) begin
            m_has[i] = have[i];
            m_evt[i] = me[i] ? (evt_n ^ 20'd1) : evt_n;
            m_bc[i]  = mb[i] ? (bc ^ 12'd1) : bc;
            m_len[i] = i % 4;
            d_cnt[i] = have[i] ? (i % 4) : 0;
            d_rd[i]  = 0;
            for (int k = 0; k < 8; k++) d_mem[i][k] = 32'hD000_0000 | (i << 16) | (evt_n[7:0] << 8) | k;
            if (en[i] && lu[i] && !have[i]) rdy = 0;
            if (en[i]) begin
                if (!lu[i]) ldb[i] = 1;
                else if (!have[i]) tob[i] = 1;
                else begin
                    if (me[i] || mb[i]) begin
                        mmb[i] = 1;
                        push({m_evt[i], m_bc[i]}, "R9 source id word");
                        nstd++;
                    end
                    for (int k = 0; k < i % 4; k++) begin
                        push(d_mem[i][k], "R10 payload word");
                        nstd++;
                    end
                end
            end
        end
        push({tob, ldb}, "R7 R8 status A");
        push({16'h0, mmb}, "R9 status B");
        push(32'(nstd + 3), "R11 word count");
        push(XT, "R5 xport trailer");
        trig_evt = evt_n;
        trig_bc  = bc;
        stall    = stl;
        t_has    = 1;
        if (nospace > 0) begin
            out_space = 0;
            drive();
            seen = 0;
            for (int c = 0; c < nospace; c++) begin
                @(negedge clk);
                if (out_we) seen++;
            end
            // R2: no words while the output memory has no room
            check(seen == 0, "R2 write without space", 32'(seen), 32'h0);
            out_space = 1;
        end
        drive();
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!out_we && lat < 1000);
        expl = rdy ? 1 : tmo + 1;
        check(lat == expl, rdy ? "R3 start latency" : "R4 timeout latency", 32'(lat), 32'(expl));
        guard = 0;
        while (exp_q.size() > 0 && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        check(exp_q.size() == 0, {"R5 fragment incomplete ", tag}, 32'(exp_q.size()), 32'h0);
        // R12: record consumed
        check(t_has == 0, "R12 timing record popped", 32'(t_has), 32'h0);
        for (int i = 0; i < N; i++) begin
            if (!en[i] && have[i]) begin
                // R6: disabled source left untouched
                check(m_has[i] && d_rd[i] == 0, "R6 disabled source popped", 32'(d_rd[i]), 32'h0);
            end
            if (en[i] && lu[i] && have[i]) begin
                // R10: all payload and the management entry consumed
                check(!m_has[i] && d_rd[i] == d_cnt[i], "R10 source consumption", 32'(d_rd[i]), 32'(d_cnt[i]));
            end
        end
        exp_q.delete();
        exp_r.delete();
        for (int i = 0; i < N; i++) begin
            m_has[i] = 0; d_cnt[i] = 0; d_rd[i] = 0;
        end
        drive();
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_has[i] = 0; d_cnt[i] = 0; d_rd[i] = 0; m_len[i] = 0;
            m_evt[i] = '0; m_bc[i] = '0;
        end
        drive();
        repeat (3) @(negedge clk);
        // R1: quiet during reset
        check(!out_we && !trig_pop && mgmt_pop == '0 && dat_pop == '0, "R1 reset outputs",
              {30'h0, out_we, trig_pop}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet in the first cycle after reset
        check(!out_we && mgmt_pop == '0 && dat_pop == '0, "R1 after reset", {31'h0, out_we}, 32'h0);

        // R3 R5 R10 R11: every source present and ready
        run_event(12'hFFF, 12'hFFF, 12'hFFF, 12'h000, 12'h000, 50, 0, 0, "all");
        // R6: source 3 disabled but holding data
        run_event(12'hFF7, 12'hFFF, 12'hFFF, 12'h000, 12'h000, 50, 0, 0, "disabled");
        // R7: source 5 link down
        run_event(12'hFFF, 12'hFDF, 12'hFDF, 12'h000, 12'h000, 50, 0, 0, "linkdown");
        // R4 R8: source 7 without data, timer expires
        run_event(12'hFFF, 12'hFFF, 12'hF7F, 12'h000, 12'h000, 20, 0, 0, "timeout");
        // R9: source 2 event mismatch, source 9 bunch mismatch, source 4 zero-length mismatch
        run_event(12'hFFF, 12'hFFF, 12'hFFF, 12'h014, 12'h200, 50, 0, 0, "mismatch");
        // R13: data queues withheld at the start of the payload copy
        run_event(12'hFFF, 12'hFFF, 12'hFFF, 12'h000, 12'h000, 50, 9, 0, "stall");
        // R2: record waiting without output room, then timeout with several sources missing
        run_event(12'h0FF, 12'hFFE, 12'h0F0, 12'h000, 12'h000, 7, 0, 30, "nospace");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule